// File: doc/BRIEF.md
# Comma-Locked Symbol Aligner

This block sits after a serial-to-parallel converter. The converter delivers 10-bit words, but it does not know where one line-code symbol ends and the next begins, so the symbol boundary inside each word is arbitrary. The aligner joins the previous accepted word and the current word into a 20-bit window. It then checks the ten possible boundary positions in that window for either disparity form of the K28.5 comma. When it finds a comma, it fixes that position and from then on cuts properly bounded symbols out of the window. These go to an 8b/10b decoder.

Each output symbol carries a valid qualifier, because the input stream may have gaps and the data later crosses an elastic buffer. A comma flag marks comma symbols. A locked flag shows that a boundary has been fixed. If commas keep showing up at a different boundary, the block moves to that boundary after a fixed number of consecutive confirmations. A one-cycle realign pulse marks the move.

Top module: `comma_aligner`

## Requirements
- R1: While `rst_ni` is low and right after it is released, `valid_o`, `locked_o`, `comma_o` and `realign_o` are all 0. Reset also discards the stored boundary and the stored previous word.
- R2: Serial order is the MSB first. The window is {previous accepted word, current word}. Candidate k (0..9) is window bits [19-k:10-k]. The comma codes are 10'b0011111010 and 10'b1100000101. Either code is recognised at any of the ten candidates.
- R3: Until the first comma is found, `valid_o` stays 0, whatever the input.
- R4: On the first comma, the output register carries the comma symbol, with `valid_o`, `comma_o` and `locked_o` all 1 in the same cycle. The matching candidate k becomes the stored boundary.
- R5: Once locked, each input word taken with `valid_i`=1 produces exactly one output with `valid_o`=1, two clock edges later. That output is candidate k of the window the word completes. A cycle with `valid_i`=0 produces `valid_o`=0 two edges later.
- R6: `comma_o` is 1 only on valid outputs whose symbol is one of the two comma codes at the stored boundary.
- R7: While locked, suppose three consecutive comma occurrences all match at one candidate that differs from the stored boundary. On the third occurrence the block adopts that candidate and outputs the comma at it, with `comma_o`=1 and `realign_o`=1 for that one cycle.
- R8: A comma found at the stored boundary restarts the count of R7, so mismatching commas separated by such a comma never trigger a realignment.
- R9: Once set, `locked_o` stays 1 until reset. `realign_o` is never 1 while unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word present this cycle |
| data_i | input | 10 | Unaligned word from the deserializer, MSB received first |
| valid_o | output | 1 | Aligned symbol present |
| sym_o | output | 10 | Aligned symbol, MSB first |
| comma_o | output | 1 | Current symbol is a comma at the stored boundary |
| locked_o | output | 1 | A symbol boundary is fixed |
| realign_o | output | 1 | One-cycle pulse when the boundary moves |

## Verification
The assertions assume that a legal line-code stream contains at most one comma in any 20-bit window. This holds because commas in the stream are far apart. The lowest-candidate choice and the confirmation count are therefore never asked to resolve two simultaneous hits.

The stimulus builds every stream from filler and data symbols whose runs of equal bits are no longer than four. Inserted slip bits alternate against their neighbour. This way the only run of five, and so the only possible match, is inside a deliberately placed comma. The sweep covers every starting boundary with both comma polarities, a mid-stream gap, a slip that must be confirmed three times, and slips broken up by a comma at the original boundary.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;
  localparam int unsigned SYM_W = 10;
  localparam logic [SYM_W-1:0] K28_POS = 10'b0011111010;
  localparam logic [SYM_W-1:0] K28_NEG = 10'b1100000101;

  function automatic logic is_k28(input logic [SYM_W-1:0] s);
    return (s == K28_POS) || (s == K28_NEG);
  endfunction
endpackage

// File: rtl/comma_detect.sv
module comma_detect
  import comma_align_pkg::*;
#(
  parameter int unsigned W = SYM_W
) (
  input  logic [2*W-1:0] win_i,
  output logic [W-1:0]   hit_o
);
  // candidate k starts k bits after the window's oldest bit
  for (genvar k = 0; k < W; k++) begin : g_cand
    assign hit_o[k] = is_k28(win_i[2*W-1-k -: W]);
  end
endmodule

// File: rtl/offset_select.sv
module offset_select #(
  parameter int unsigned W  = 10,
  parameter int unsigned OW = $clog2(W)
) (
  input  logic [2*W-1:0] win_i,
  input  logic [OW-1:0]  off_i,
  output logic [W-1:0]   sym_o
);
  logic [2*W-1:0] shifted;

  always_comb begin
    shifted = win_i >> (W - int'(off_i));
    sym_o   = shifted[W-1:0];
  end
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl #(
  parameter int unsigned W       = 10,
  parameter int unsigned CONFIRM = 3,
  parameter int unsigned OW      = $clog2(W),
  parameter int unsigned CW      = $clog2(CONFIRM + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          v_i,
  input  logic [W-1:0]  hit_i,
  output logic          locked_o,
  output logic [OW-1:0] use_off_o,
  output logic          emit_o,
  output logic          comma_o,
  output logic          realign_o
);
  logic          lock_q, lock_n;
  logic [OW-1:0] off_q, off_n, cand_q, cand_n, first_off;
  logic [CW-1:0] cnt_q, cnt_n, cnt_inc;
  logic          any_hit;

  always_comb begin
    first_off = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_i[k]) first_off = OW'(k);
    end
  end

  assign any_hit = |hit_i;

  always_comb begin
    lock_n    = lock_q;
    off_n     = off_q;
    cand_n    = cand_q;
    cnt_n     = cnt_q;
    cnt_inc   = '0;
    use_off_o = off_q;
    emit_o    = 1'b0;
    comma_o   = 1'b0;
    realign_o = 1'b0;
    if (v_i) begin
      if (!lock_q) begin
        if (any_hit) begin
          lock_n    = 1'b1;
          off_n     = first_off;
          use_off_o = first_off;
          emit_o    = 1'b1;
          comma_o   = 1'b1;
          cnt_n     = '0;
        end
      end else begin
        emit_o = 1'b1;
        if (hit_i[off_q]) begin
          comma_o = 1'b1;
          cnt_n   = '0;
        end else if (any_hit) begin
          cnt_inc = (cnt_q != '0 && cand_q == first_off) ? cnt_q + 1'b1 : CW'(1);
          cand_n  = first_off;
          if (cnt_inc == CW'(CONFIRM)) begin
            off_n     = first_off;
            use_off_o = first_off;
            comma_o   = 1'b1;
            realign_o = 1'b1;
            cnt_n     = '0;
          end else begin
            cnt_n = cnt_inc;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      off_q  <= '0;
      cand_q <= '0;
      cnt_q  <= '0;
    end else begin
      lock_q <= lock_n;
      off_q  <= off_n;
      cand_q <= cand_n;
      cnt_q  <= cnt_n;
    end
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import comma_align_pkg::*;
#(
  parameter int unsigned W       = SYM_W,
  parameter int unsigned CONFIRM = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] sym_o,
  output logic         comma_o,
  output logic         locked_o,
  output logic         realign_o
);
  localparam int unsigned OW = $clog2(W);

  logic [W-1:0]   hist_q;
  logic           hist_vld_q;
  logic [2*W-1:0] win, win_q;
  logic [W-1:0]   hit, hit_q;
  logic           win_vld, v1_q;
  logic [OW-1:0]  use_off;
  logic           emit, is_comma, realign;
  logic [W-1:0]   sym;

  assign win     = {hist_q, data_i};
  assign win_vld = valid_i & hist_vld_q;

  comma_detect #(.W(W)) u_detect (.win_i(win), .hit_o(hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q     <= '0;
      hist_vld_q <= 1'b0;
      win_q      <= '0;
      hit_q      <= '0;
      v1_q       <= 1'b0;
    end else begin
      v1_q <= win_vld;
      if (valid_i) begin
        hist_q     <= data_i;
        hist_vld_q <= 1'b1;
      end
      if (win_vld) begin
        win_q <= win;
        hit_q <= hit;
      end
    end
  end

  lock_ctrl #(.W(W), .CONFIRM(CONFIRM)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .v_i      (v1_q),
    .hit_i    (hit_q),
    .locked_o (locked_o),
    .use_off_o(use_off),
    .emit_o   (emit),
    .comma_o  (is_comma),
    .realign_o(realign)
  );

  offset_select #(.W(W)) u_sel (.win_i(win_q), .off_i(use_off), .sym_o(sym));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sym_o     <= '0;
      comma_o   <= 1'b0;
      realign_o <= 1'b0;
    end else begin
      valid_o   <= emit;
      comma_o   <= is_comma;
      realign_o <= realign;
      if (emit) sym_o <= sym;
    end
  end
endmodule

// File: rtl/comma_aligner_chk.sv
module comma_aligner_chk
  import comma_align_pkg::*;
#(
  parameter int unsigned W = SYM_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         valid_o,
  input logic [W-1:0] sym_o,
  input logic         comma_o,
  input logic         locked_o,
  input logic         realign_o
);
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> locked_o); // R3

  AST_FIRST_LOCK_COMMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> valid_o && comma_o); // R4

  AST_LOCKED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o) && $past(valid_i, 2)) |-> valid_o); // R5

  AST_VALID_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(locked_o)) |-> $past(valid_i, 2)); // R5

  AST_COMMA_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comma_o |-> valid_o && (sym_o == K28_POS || sym_o == K28_NEG)); // R6

  AST_REALIGN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |=> !realign_o); // R7

  AST_REALIGN_ON_COMMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |-> valid_o && comma_o && locked_o); // R9

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o); // R9
endmodule

bind comma_aligner comma_aligner_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .valid_o  (valid_o),
  .sym_o    (sym_o),
  .comma_o  (comma_o),
  .locked_o (locked_o),
  .realign_o(realign_o)
);

// File: tb/tb_comma_aligner.sv
module tb_comma_aligner;
  localparam logic [9:0] KP = 10'b0011111010;
  localparam logic [9:0] KN = 10'b1100000101;
  localparam logic [9:0] FILL = 10'b1010101010;
  localparam int MAXB = 1200;
  localparam int MAXW = 110;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [9:0] data_i = '0;
  logic valid_o, comma_o, locked_o, realign_o;
  logic [9:0] sym_o;

  comma_aligner dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .sym_o(sym_o), .comma_o(comma_o),
    .locked_o(locked_o), .realign_o(realign_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit sb [MAXB];
  int nb;
  logic res_v [MAXW], res_c [MAXW], res_l [MAXW], res_r [MAXW];
  logic [9:0] res_s [MAXW];
  int last_tag;
  logic gap_seen;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] dsym(input int i);
    case (i % 6)
      0: return 10'b1001100110;
      1: return 10'b0101010101;
      2: return 10'b0110011001;
      3: return 10'b1001011010;
      4: return 10'b1010101010;
      default: return 10'b0110100101;
    endcase
  endfunction

  task automatic push_sym(input logic [9:0] s);
    for (int b = 9; b >= 0; b--) begin
      sb[nb] = s[b];
      nb++;
    end
  endtask

  // alternating bits, starting opposite to the last bit so no run grows
  task automatic push_alt(input int n);
    for (int i = 0; i < n; i++) begin
      sb[nb] = (nb == 0) ? 1'b1 : ~sb[nb-1];
      nb++;
    end
  endtask

  function automatic logic [9:0] word_at(input int j);
    logic [9:0] w;
    for (int b = 0; b < 10; b++) w[9-b] = sb[10*j+b];
    return w;
  endfunction

  function automatic logic [9:0] exp_sym(input int j, input int k);
    logic [9:0] s;
    for (int b = 0; b < 10; b++) s[9-b] = sb[10*(j-1)+k+b];
    return s;
  endfunction

  task automatic step(input logic v, input logic [9:0] d, input int tag);
    valid_i = v;
    data_i  = d;
    @(posedge clk);
    @(negedge clk);
    if (last_tag >= 0) begin
      res_v[last_tag] = valid_o;
      res_s[last_tag] = sym_o;
      res_c[last_tag] = comma_o;
      res_l[last_tag] = locked_o;
      res_r[last_tag] = realign_o;
    end else if (last_tag == -1) begin
      gap_seen = gap_seen | valid_o;
    end
    last_tag = tag;
  endtask

  task automatic run_words(input int nw, input int gap_at);
    last_tag = -2;
    gap_seen = 1'b0;
    for (int j = 0; j < MAXW; j++) begin
      res_v[j] = 0; res_c[j] = 0; res_l[j] = 0; res_r[j] = 0; res_s[j] = '0;
    end
    for (int j = 0; j < nw; j++) begin
      if (j == gap_at) step(1'b0, 10'h3FF, -1);
      step(1'b1, word_at(j), j);
    end
    step(1'b0, '0, -2);
  endtask

  task automatic do_reset();
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!valid_o && !locked_o && !comma_o && !realign_o, "R1", "outputs in reset",
        {valid_o, locked_o, comma_o, realign_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!valid_o && !locked_o, "R1", "outputs after release", {valid_o, locked_o}, 0);
    nb = 0;
  endtask

  int nw, jr, rcount, c3, cold;
  bit ok;

  initial begin
    @(negedge clk);
    // sweep all boundaries and both polarities
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 10; k++) begin
        do_reset();
        push_alt(k);
        push_sym(FILL); push_sym(FILL);
        push_sym(p == 0 ? KP : KN);
        for (int i = 0; i < 10; i++) push_sym(dsym(i + k));
        nw = nb / 10;
        run_words(nw, p == 1 ? 6 : -1);
        ok = 1;
        for (int j = 0; j < 3; j++) if (res_v[j] || res_l[j]) ok = 0;
        chk(ok, "R3", $sformatf("no output before comma k=%0d p=%0d", k, p), ok, 1);
        chk(res_v[3] && res_c[3] && res_l[3] && res_s[3] == (p == 0 ? KP : KN),
            "R4", $sformatf("first comma k=%0d p=%0d", k, p), res_s[3], p == 0 ? KP : KN);
        ok = 1;
        for (int j = 4; j < nw; j++)
          if (!res_v[j] || res_c[j] || res_s[j] != exp_sym(j, k)) ok = 0;
        chk(ok, "R5", $sformatf("aligned stream R2 candidate k=%0d p=%0d", k, p), ok, 1);
        if (p == 1) chk(!gap_seen, "R5", "gap yields no valid", gap_seen, 0);
      end
    end

    // R7: slip by 4 bits confirmed three times
    do_reset();
    push_alt(3);
    push_sym(FILL); push_sym(FILL); push_sym(KP);
    for (int i = 0; i < 3; i++) push_sym(dsym(i));
    push_alt(4);
    for (int r = 0; r < 3; r++) begin
      if (r == 2) c3 = nb;
      push_sym(KP);
      for (int i = 0; i < 3; i++) push_sym(dsym(i + r + 1));
    end
    for (int i = 0; i < 4; i++) push_sym(dsym(i + 2));
    nw = nb / 10;
    run_words(nw, -1);
    jr = (c3 - 7) / 10 + 1;
    rcount = 0;
    for (int j = 0; j < nw; j++) if (res_r[j]) rcount++;
    chk(rcount == 1, "R7", "single realign pulse", rcount, 1);
    chk(res_r[jr] && res_c[jr] && res_v[jr] && res_s[jr] == KP, "R7",
        "realign on third slipped comma", res_s[jr], KP);
    ok = 1;
    for (int j = jr + 1; j < nw; j++) if (!res_v[j] || res_s[j] != exp_sym(j, 7)) ok = 0;
    chk(ok, "R7", "stream at new boundary", ok, 1);
    ok = 1;
    for (int j = 4; j < nw; j++) if (!res_l[j]) ok = 0;
    chk(ok, "R9", "lock held through slip", ok, 1);

    // R8: slipped commas interrupted by one at the stored boundary
    do_reset();
    push_alt(3);
    push_sym(FILL); push_sym(FILL); push_sym(KN);
    for (int i = 0; i < 3; i++) push_sym(dsym(i));
    push_alt(4);
    for (int r = 0; r < 2; r++) begin
      push_sym(KN);
      for (int i = 0; i < 3; i++) push_sym(dsym(i + r));
    end
    push_alt(6);
    cold = nb;
    push_sym(KN);
    for (int i = 0; i < 3; i++) push_sym(dsym(i + 3));
    push_alt(4);
    for (int r = 0; r < 2; r++) begin
      push_sym(KN);
      for (int i = 0; i < 3; i++) push_sym(dsym(i + r + 1));
    end
    for (int i = 0; i < 3; i++) push_sym(dsym(i));
    nw = nb / 10;
    run_words(nw, -1);
    rcount = 0;
    for (int j = 0; j < nw; j++) if (res_r[j]) rcount++;
    chk(rcount == 0, "R8", "no realign when count restarted", rcount, 0);
    jr = (cold - 3) / 10 + 1;
    chk(res_v[jr] && res_c[jr] && res_s[jr] == KN && res_s[jr] == exp_sym(jr, 3), "R6",
        "comma at stored boundary flagged", res_s[jr], KN);
    ok = 1;
    for (int j = 3; j < nw; j++) if (res_c[j] && res_s[j] != KN) ok = 0;
    chk(ok, "R6", "comma flag only on comma codes", ok, 1);
    ok = 1;
    for (int j = 4; j < nw; j++) if (!res_l[j] || !res_v[j]) ok = 0;
    chk(ok, "R9", "lock held, every word emitted", ok, 1);

    do_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule